// File: doc/BRIEF.md
# SPI Parameter Page Read Engine

This block is the read path of a serial flash device for a small, separate 256-byte parameter page that holds serial numbers, revision codes and configuration words. It acts as an SPI slave in clock mode 0. The master lowers the chip select, then clocks in an 8-bit opcode followed by a 24-bit address, most significant bit first, with the slave sampling on rising clock edges. If the opcode is the parameter-page read code and the device is not busy, the engine starts driving page bytes on falling clock edges. Each byte is sent most significant bit first, and the byte address steps forward after every byte.

Only the low eight address bits choose the starting byte. A continuous read runs past byte 255 and carries on at byte 0. Raising chip select ends the command at any point, including partway through a byte. When a program, erase or write cycle is in progress, as flagged by the busy input, the command is refused. In that case the data line stays released until chip select rises. The page contents are loaded through a synchronous back-door write port.

The SPI pins are sampled by the system clock through a synchronizer, so the SPI clock must be several times slower than the system clock.

Top module: `ppage_read_engine`

## Requirements
- R1: After reset, with chip select high, `spi_so_oe` is 0 and `spi_so` is 0.
- R2: The command byte is shifted in MSB first on rising `spi_sck` edges. Only the value 8'h53 starts a read. Any other value is ignored: `spi_so_oe` stays 0 until chip select rises.
- R3: Of the 24 address bits, which arrive MSB first after the opcode, only the last eight (A7..A0) select the starting byte. A23..A8 have no effect on the data returned.
- R4: The first data bit is driven on the falling `spi_sck` edge that follows the rising edge of the last address bit. Each byte is sent MSB first, one bit per falling edge. `spi_so_oe` is 0 during the opcode and address phases and 1 from that first data edge on.
- R5: After the eighth bit of a byte, the next byte sent is the one at the next higher page address, without any gap.
- R6: A continuous read that passes page byte 255 continues at byte 0.
- R7: Raising chip select at any time, including in the middle of a byte, drops `spi_so_oe` to 0. The next command is then decoded from its first bit.
- R8: If `busy_i` is 1 on the rising edge that completes the opcode, the command is rejected. `spi_so_oe` stays 0 for the rest of that chip-select-low period, and a later read with `busy_i` at 0 returns normal data.
- R9: A system clock edge with `pg_wr_en` at 1 stores `pg_wr_data` at page byte `pg_wr_addr`. Later reads of that byte return the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than spi_sck |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_si | input | 1 | Serial data from the master |
| spi_so | output | 1 | Serial data to the master |
| spi_so_oe | output | 1 | Output enable for spi_so (1 = drive, 0 = high impedance) |
| busy_i | input | 1 | A program, erase or write cycle is in progress |
| pg_wr_en | input | 1 | Back-door page write enable |
| pg_wr_addr | input | 8 | Back-door page write byte address |
| pg_wr_data | input | 8 | Back-door page write data |

## Verification
The byte pointer is internal, so the only place an error in it can appear is the data stream. An address that is off by one, loses upper bits, or wraps at the wrong point shows up as a wrong byte in the first byte it affects, which is eight SPI clocks after the fault at most. A wrong bit counter shows up in other ways: the output enable rises one edge early or late, or the bytes come out rotated. A sequencer state that is not cleared when chip select rises, or a rejected command treated as accepted, shows up as the output enable being driven when it should not be. The bench samples each data bit in the low half of the SPI clock and compares each byte with a reference model of the page.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_REJECT
    } pp_state_e;

    localparam logic [7:0] PP_READ_OPCODE = 8'h53;

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stage_d[s] = d_i;
            end else begin : g_next
                assign stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pp_page_mem.sv
module pp_page_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];

    // R9: a back-door write lands in the addressed byte
    a_r9_backdoor_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/pp_read_fsm.sv
module pp_read_fsm
    import pp_pkg::*;
#(
    parameter int             CMD_BITS  = 8,
    parameter int             ADDR_BITS = 24,
    parameter int             PAGE_AW   = 8,
    parameter int             DW        = 8,
    parameter logic [CMD_BITS-1:0] OPCODE = PP_READ_OPCODE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               cs_n_s,
    input  logic               si_s,
    input  logic               busy_i,
    input  logic [DW-1:0]      rd_data,
    output logic [PAGE_AW-1:0] rd_addr,
    output logic               so_o,
    output logic               so_oe_o
);

    localparam int CNT_MAX = (ADDR_BITS > CMD_BITS) ? ADDR_BITS : CMD_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int BI_W    = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        pp_state_e             state;
        logic [CNT_W-1:0]      cnt;
        logic [CMD_BITS-1:0]   op;
        logic [PAGE_AW-1:0]    addr;
        logic [BI_W-1:0]       bitidx;
        logic                  sck_prev;
        logic                  so;
        logic                  oe;
    } fsm_t;

    fsm_t r_q, r_d;
    logic sck_rise, sck_fall;
    logic [CMD_BITS-1:0] op_full;

    assign sck_rise = sck_s & ~r_q.sck_prev;
    assign sck_fall = ~sck_s & r_q.sck_prev;
    assign op_full  = {r_q.op[CMD_BITS-2:0], si_s};

    always_comb begin
        r_d          = r_q;
        r_d.sck_prev = sck_s;
        if (cs_n_s) begin
            r_d.state  = ST_IDLE;
            r_d.cnt    = '0;
            r_d.so     = 1'b0;
            r_d.oe     = 1'b0;
            r_d.bitidx = BI_W'(DW-1);
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    r_d.state = ST_CMD;
                    r_d.cnt   = '0;
                end
                ST_CMD: begin
                    if (sck_rise) begin
                        r_d.op = op_full;
                        if (r_q.cnt == CNT_W'(CMD_BITS-1)) begin
                            r_d.cnt   = '0;
                            r_d.state = (op_full == OPCODE && !busy_i) ? ST_ADDR : ST_REJECT;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        r_d.addr = {r_q.addr[PAGE_AW-2:0], si_s};
                        if (r_q.cnt == CNT_W'(ADDR_BITS-1)) begin
                            r_d.cnt    = '0;
                            r_d.state  = ST_DATA;
                            r_d.bitidx = BI_W'(DW-1);
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (sck_fall) begin
                        r_d.so = rd_data[r_q.bitidx];
                        r_d.oe = 1'b1;
                        if (r_q.bitidx == '0) begin
                            r_d.bitidx = BI_W'(DW-1);
                            r_d.addr   = r_q.addr + 1'b1;
                        end else begin
                            r_d.bitidx = r_q.bitidx - 1'b1;
                        end
                    end
                end
                ST_REJECT: begin
                    r_d.oe = 1'b0;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.cnt      <= '0;
            r_q.op       <= '0;
            r_q.addr     <= '0;
            r_q.bitidx   <= BI_W'(DW-1);
            r_q.sck_prev <= 1'b0;
            r_q.so       <= 1'b0;
            r_q.oe       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr = r_q.addr;
    assign so_o    = r_q.so;
    assign so_oe_o = r_q.oe;

    // R7: chip select high releases the data line on the next clock
    a_r7_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !so_oe_o);

    // R8: a rejected command never drives the line
    a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_REJECT) |-> !so_oe_o);

    // R2: a wrong opcode leads to the rejecting state
    a_r2_wrong_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && sck_rise && r_q.state == ST_CMD &&
         r_q.cnt == CNT_W'(CMD_BITS-1) && op_full != OPCODE) |=> (r_q.state == ST_REJECT));

    // R4: output enable only during the data phase
    a_r4_oe_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe_o |-> (r_q.state == ST_DATA));

    // R4: data bit changes only on a falling SPI clock edge
    a_r4_so_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !sck_fall && r_q.state == ST_DATA) |=> $stable(so_o));

    // R5: byte pointer steps by one after the last bit of a byte
    a_r5_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && sck_fall && r_q.state == ST_DATA && r_q.bitidx == '0)
        |=> (rd_addr == $past(rd_addr) + 1'b1));

    // R6: pointer wraps from the top byte to byte zero
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && sck_fall && r_q.state == ST_DATA && r_q.bitidx == '0 && rd_addr == '1)
        |=> (rd_addr == '0));

endmodule

// File: rtl/ppage_read_engine.sv
module ppage_read_engine #(
    parameter int CMD_BITS    = 8,
    parameter int ADDR_BITS   = 24,
    parameter int PAGE_AW     = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_si,
    output logic               spi_so,
    output logic               spi_so_oe,
    input  logic               busy_i,
    input  logic               pg_wr_en,
    input  logic [PAGE_AW-1:0] pg_wr_addr,
    input  logic [DW-1:0]      pg_wr_data
);

    localparam int NSYNC = 3;

    logic [NSYNC-1:0]   pins_s;
    logic [PAGE_AW-1:0] rd_addr;
    logic [DW-1:0]      rd_data;

    pp_sync #(
        .WIDTH   (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({spi_si, spi_cs_n, spi_sck}),
        .q_o   (pins_s)
    );

    pp_page_mem #(
        .AW (PAGE_AW),
        .DW (DW)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pg_wr_en),
        .wr_addr (pg_wr_addr),
        .wr_data (pg_wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    pp_read_fsm #(
        .CMD_BITS  (CMD_BITS),
        .ADDR_BITS (ADDR_BITS),
        .PAGE_AW   (PAGE_AW),
        .DW        (DW)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (pins_s[0]),
        .cs_n_s  (pins_s[1]),
        .si_s    (pins_s[2]),
        .busy_i  (busy_i),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .so_o    (spi_so),
        .so_oe_o (spi_so_oe)
    );

    // R1: released data line right after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $fell(rst_n) |=> (!spi_so_oe && !spi_so));

endmodule

// File: tb/sim_ppage_read_engine.sv
`timescale 1ns/1ps
module sim_ppage_read_engine;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_si = 1'b0;
    logic       spi_so;
    logic       spi_so_oe;
    logic       busy_i = 1'b0;
    logic       pg_wr_en = 1'b0;
    logic [7:0] pg_wr_addr = '0;
    logic [7:0] pg_wr_data = '0;

    int checks = 0;
    int failures = 0;
    logic [7:0] ref_mem [256];
    bit oe_seen_cmd;

    always #2 clk = ~clk;

    ppage_read_engine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (spi_sck),
        .spi_cs_n   (spi_cs_n),
        .spi_si     (spi_si),
        .spi_so     (spi_so),
        .spi_so_oe  (spi_so_oe),
        .busy_i     (busy_i),
        .pg_wr_en   (pg_wr_en),
        .pg_wr_addr (pg_wr_addr),
        .pg_wr_data (pg_wr_data)
    );

    function automatic logic [7:0] exp_byte(logic [23:0] start, int idx);
        logic [7:0] a;
        a = 8'(start[7:0] + idx);
        return ref_mem[a];
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bd_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        pg_wr_en = 1'b1; pg_wr_addr = a; pg_wr_data = d;
        @(negedge clk);
        pg_wr_en = 1'b0;
        ref_mem[a] = d;
    endtask

    task automatic send_bit(logic b);
        spi_si = b;
        half_wait();
        if (spi_so_oe) oe_seen_cmd = 1'b1;
        spi_sck = 1'b1;
        half_wait();
        spi_sck = 1'b0;
    endtask

    task automatic send_cmd(logic [7:0] op, logic [23:0] ad);
        oe_seen_cmd = 1'b0;
        spi_cs_n = 1'b0;
        half_wait();
        for (int i = 7; i >= 0; i--) send_bit(op[i]);
        for (int i = 23; i >= 0; i--) send_bit(ad[i]);
    endtask

    task automatic read_bits(int nbits, output logic [7:0] v, output bit oe_all, output bit oe_any);
        v = '0; oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            half_wait();
            v = {v[6:0], spi_so};
            oe_all &= spi_so_oe;
            oe_any |= spi_so_oe;
            spi_sck = 1'b1;
            half_wait();
            spi_sck = 1'b0;
        end
    endtask

    task automatic end_cmd(string req);
        half_wait();
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        check(spi_so_oe == 1'b0, req, {31'd0, spi_so_oe}, 32'd0);
    endtask

    task automatic read_check(logic [23:0] ad, int nbytes, string req);
        logic [7:0] v; bit oa; bit on;
        send_cmd(8'h53, ad);
        check(!oe_seen_cmd, "R4 oe low in cmd/addr", {31'd0, oe_seen_cmd}, 32'd0);
        for (int b = 0; b < nbytes; b++) begin
            read_bits(8, v, oa, on);
            check(v == exp_byte(ad, b) && oa, req, {23'd0, oa, v}, {24'd1, exp_byte(ad, b)});
        end
        end_cmd("R7 release after read");
    endtask

    task automatic reject_check(logic [7:0] op, logic [23:0] ad, string req);
        logic [7:0] v; bit oa; bit on;
        send_cmd(op, ad);
        read_bits(16, v, oa, on);
        check(!on && !oe_seen_cmd, req, {30'd0, on, oe_seen_cmd}, 32'd0);
        end_cmd(req);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        repeat (148000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v; bit oa; bit on;
        void'($urandom(32'h5A17_C0DE));
        repeat (6) @(negedge clk);
        // R1: reset state
        check(spi_so_oe == 1'b0, "R1 oe in reset", {31'd0, spi_so_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(spi_so_oe == 1'b0 && spi_so == 1'b0, "R1 idle after reset",
              {30'd0, spi_so_oe, spi_so}, 32'd0);

        // R9: load the page through the back door
        for (int i = 0; i < 256; i++) bd_write(8'(i), 8'($urandom));

        // R4/R5: basic stream from byte 0x10
        read_check(24'h000010, 3, "R5 sequential bytes");
        // R3: upper address bits ignored
        read_check(24'hABCD10, 2, "R3 upper address ignored");
        read_check(24'hFFFF10, 1, "R3 upper address all ones");
        // R6: wrap past the last byte
        read_check(24'h0000FE, 4, "R6 wrap 255 to 0");
        read_check(24'h1234FF, 2, "R6 wrap from top byte");

        // R2: other opcodes are ignored
        reject_check(8'h03, 24'h000010, "R2 wrong opcode 03");
        reject_check(8'h52, 24'h000010, "R2 wrong opcode 52");

        // R8: busy at opcode completion rejects
        busy_i = 1'b1;
        reject_check(8'h53, 24'h000020, "R8 busy reject");
        busy_i = 1'b0;
        read_check(24'h000020, 2, "R8 read after busy clears");

        // R7: abort in the middle of a byte, then a fresh read
        send_cmd(8'h53, 24'h000040);
        read_bits(3, v, oa, on);
        check(v[2:0] == exp_byte(24'h40, 0) >> 5 && oa, "R4 partial byte MSB first",
              {28'd0, oa, v[2:0]}, {28'd1, 3'(exp_byte(24'h40, 0) >> 5)});
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        check(spi_so_oe == 1'b0, "R7 mid-byte abort releases", {31'd0, spi_so_oe}, 32'd0);
        read_check(24'h000041, 2, "R7 fresh command after abort");

        // R9: rewrite a byte and read it back
        bd_write(8'h77, 8'hC3);
        bd_write(8'h78, 8'h3C);
        read_check(24'h000077, 2, "R9 back-door rewrite");

        // Random reads
        for (int t = 0; t < 24; t++) begin
            logic [23:0] ad;
            int n;
            ad = 24'($urandom);
            n = 1 + int'($urandom % 5);
            if (t % 6 == 5) bd_write(8'($urandom), 8'($urandom));
            read_check(ad, n, "R5 random stream");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule